// File: doc/BRIEF.md
# Counting Sequential Divider

This block divides one unsigned 16-bit operand by another. It does not use a shift-and-subtract loop. It loads the dividend into a working remainder and then, once per clock, takes the divisor away from it. A quotient counter goes up by one each time the difference stays non-negative. The run stops at the first cycle in which the remainder is below the divisor. At that point the count is the quotient and the working value is the remainder. The latency therefore tracks the size of the quotient rather than the operand width. The block suits paths where quotients are usually small, or where area counts for more than worst-case delay.

A caller drives the two operands and pulses `start` while `busy` is low. Acceptance follows a simple back-pressure rule: `busy` low means the block is ready, and a `start` seen while `busy` is high is dropped. `done` marks completion for one cycle. From that cycle until the next accepted `start`, `quotient`, `remainder` and `err` stay constant. A zero divisor is caught when the operation is accepted, and the block finishes immediately with `err` set.

Top module: `rsdiv_top`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `done`, `err`, `quotient` and `remainder` all become zero.
- R2: A `start` taken while idle with a non-zero `divisor` makes `busy` 1, `quotient` 0, `remainder` equal to `dividend` and `err` 0 in the following cycle.
- R3: In each busy cycle where `remainder` is at least the latched divisor, the next cycle shows `remainder` reduced by the divisor and `quotient` increased by one.
- R4: In the busy cycle where `remainder` is below the latched divisor, `busy` falls and `done` rises in the next cycle, with `quotient` = dividend / divisor and `remainder` = dividend mod divisor (integer division).
- R5: For a non-zero divisor, `done` is high exactly quotient + 1 clock edges after the edge that accepts `start`.
- R6: A zero `divisor` at an accepted `start` gives, in the next cycle, `done` = 1, `err` = 1, `busy` = 0, `quotient` = 16'hFFFF and `remainder` = `dividend`.
- R7: A `start` pulse while `busy` is high has no effect: the operation in flight finishes with its original operands.
- R8: `done` is high for a single cycle per operation. While idle without `start`, `quotient`, `remainder` and `err` hold their values.
- R9: An `err` raised by a zero divisor stays high until the next accepted `start` with a non-zero divisor, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division; taken only when `busy` is low |
| dividend | input | 16 | Unsigned numerator, sampled with an accepted `start` |
| divisor | input | 16 | Unsigned denominator, sampled with an accepted `start` |
| busy | output | 1 | High while subtractions are in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set when the accepted divisor was zero |
| quotient | output | 16 | Subtraction count; final quotient once `done` is seen |
| remainder | output | 16 | Working remainder; final remainder once `done` is seen |

## Verification
The assertions assume that `rst` is held for at least one edge before the first operation. They also assume the operands matter only on the edge where an idle block sees `start`, so they may change freely at any other time. The stimulus drives every input on the falling edge and changes the operands while a division is running. It also raises `start` during a run to test that the request is dropped. Divisors of zero, one and the full range appear, along with exact, zero-quotient and longest-latency cases. Random operands use divisors large enough to keep each run short.

// File: rtl/rsdiv_pkg.sv
package rsdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rsdiv_state_e;
endpackage

// File: rtl/rsdiv_sub.sv
module rsdiv_sub #(
  parameter int W = 16
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         fits
);
  localparam int WX = W + 1;
  logic [WX-1:0] wide;

  always_comb begin
    wide = {1'b0, minuend} - {1'b0, subtrahend};
    diff = wide[W-1:0];
    fits = ~wide[W];
  end
endmodule

// File: rtl/rsdiv_path.sv
module rsdiv_path #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         load_zero,
  input  logic         step,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         fits,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] dvs;
  logic [W-1:0] diff;

  rsdiv_sub #(.W(W)) sub_i (
    .minuend   (rem),
    .subtrahend(dvs),
    .diff      (diff),
    .fits      (fits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quot <= '0;
      rem  <= '0;
      dvs  <= '0;
    end else if (load) begin
      rem  <= dividend_i;
      dvs  <= divisor_i;
      quot <= load_zero ? ALL_ONES : '0;
    end else if (step) begin
      rem  <= diff;
      quot <= quot + ONE;
    end
  end

  // R3: one accepted subtraction moves both registers by exactly one step
  assert_step_count_R3: assert property (@(posedge clk) disable iff (rst)
    step |=> (quot == $past(quot) + ONE) && (rem == $past(rem) - $past(dvs)));

  // R7: the latched divisor only changes on an accepted load
  assert_divisor_kept_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dvs));
endmodule

// File: rtl/rsdiv_ctrl.sv
module rsdiv_ctrl
  import rsdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic div_zero,
  input  logic fits,
  output logic busy,
  output logic done,
  output logic err,
  output logic load,
  output logic load_zero,
  output logic step
);
  rsdiv_state_e state;

  always_comb begin
    busy      = (state == ST_RUN);
    load      = (state == ST_IDLE) && start;
    load_zero = load && div_zero;
    step      = (state == ST_RUN) && fits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (div_zero) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              err   <= 1'b0;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (!fits) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: completion never overlaps a running operation
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/rsdiv_top.sv
module rsdiv_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic fits;
  logic load;
  logic load_zero;
  logic step;
  logic div_zero;

  assign div_zero = (divisor == '0);

  rsdiv_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .div_zero (div_zero),
    .fits     (fits),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .load     (load),
    .load_zero(load_zero),
    .step     (step)
  );

  rsdiv_path #(.W(W)) path_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_zero (load_zero),
    .step      (step),
    .dividend_i(dividend),
    .divisor_i (divisor),
    .fits      (fits),
    .quot      (quotient),
    .rem       (remainder)
  );

  // R8: idle with no request leaves the results untouched
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(err)));

  // R6: a flagged completion carries the all-ones quotient
  assert_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (quotient == '1));

  // R7: a request during a run cannot reload a larger dividend
  assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (remainder <= $past(remainder)));
endmodule

// File: tb/rsdiv_top_tb_top.sv
module rsdiv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, err;
  logic [15:0] quotient, remainder;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // behavioural reference state
  bit m_busy = 0, m_done = 0, m_err = 0;
  int m_q = 0, m_r = 0, m_d = 0;
  bit model_on = 0;

  always #2 clk = ~clk;

  rsdiv_top dut_i (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .err(err), .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_q = 0; m_r = 0; m_d = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          if (divisor == 0) begin
            m_q = 16'hFFFF; m_r = dividend; m_err = 1; m_done = 1;
          end else begin
            m_q = 0; m_r = dividend; m_d = divisor; m_err = 0; m_busy = 1;
          end
        end
      end else if (m_r >= m_d) begin
        m_r = m_r - m_d;
        m_q = m_q + 1;
      end else begin
        m_busy = 0; m_done = 1;
      end
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (model_on) begin
      check(busy, m_busy, "R2/R4/R7 busy");
      check(done, m_done, "R4/R8 done");
      check(err, m_err, "R6/R9 err");
      check(quotient, m_q, "R3 quotient");
      check(remainder, m_r, "R3 remainder");
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // launch one division; returns negedges from start to done (q+2 means q+1 edges)
  task automatic run(input int a, input int b, input bit poke_busy, output int lat);
    @(negedge clk);
    dividend = 16'(a); divisor = 16'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    dividend = 16'(a ^ 16'h5A5A); divisor = 16'(b + 3);
    while (!done && lat < 70000) begin
      if (poke_busy && lat == 2) begin
        dividend = 16'hFFFF; divisor = 16'd1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic div_case(input int a, input int b, input bit poke);
    int lat;
    run(a, b, poke, lat);
    if (b == 0) begin
      check(lat, 1, "R6 latency");
      check(err, 1, "R6 err");
      check(quotient, 16'hFFFF, "R6 quotient");
      check(remainder, a, "R6 remainder");
    end else begin
      check(lat, a / b + 2, "R5 latency");
      check(quotient, a / b, "R4 quotient");
      check(remainder, a % b, "R4 remainder");
      check(err, 0, "R9 err");
      if (poke) check(quotient, a / b, "R7 ignored start");
    end
    @(negedge clk);
    check(done, 0, "R8 single done");
    repeat (3) @(negedge clk);
    if (b == 0) check(quotient, 16'hFFFF, "R8 hold");
    else check(quotient, a / b, "R8 hold");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy, 0, "R1 busy");
    check(done, 0, "R1 done");
    check(err, 0, "R1 err");
    check(quotient, 0, "R1 quotient");
    check(remainder, 0, "R1 remainder");
    rst = 1'b0;
    model_on = 1;
    @(negedge clk);
    dividend = 16'd100; divisor = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, 1, "R2 busy");
    check(quotient, 0, "R2 quotient");
    check(remainder, 100, "R2 remainder");
    while (!done) @(negedge clk);
    check(quotient, 14, "R4 quotient");
    check(remainder, 2, "R4 remainder");
    repeat (2) @(negedge clk);
    div_case(5, 9, 0);
    div_case(21, 7, 0);
    div_case(0, 5, 0);
    div_case(1234, 0, 0);
    div_case(300, 10, 0);       // R9: err cleared
    div_case(500, 11, 1);       // R7: start during run
    div_case(65535, 65535, 0);
    div_case(65535, 1, 0);
    for (int i = 0; i < 20; i++) begin
      int a, b;
      a = int'($urandom_range(0, 65535));
      b = int'($urandom_range(64, 65535));
      div_case(a, b, i % 3 == 0);
    end
    div_case(0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule